// File: doc/BRIEF.md
# Sequential Boot Byte Streamer

This block stands in for a boot ROM that the processor only ever reads in order. It has no address inputs. Each time the active-low enable is pulsed, it presents the next byte of a fixed stream on an 8-bit data bus. Between pulses it lets go of the bus. The stream is computed when the block is built. It begins with a two-byte reset vector, which the block forces into the upper half of the 64 KiB space. Then come unconditional load-immediate / store-absolute pairs that copy a short loader into RAM, one byte per pair. An absolute jump to the start of that RAM copy ends the stream.

The enable input is synchronised to the block clock, and its deasserting edge advances a byte pointer. After the final byte has been handed over, a sticky done flag rises and the block stays off the bus until reset. The read/write sense input gates the bus drive directly, so the block never drives during a write cycle.

A build option keeps the bus driven across an enable deassertion, presenting the next byte early, whenever the byte just delivered is not the last operand of a store.

Top module: `bootseq_streamer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer returns to the first byte, `done` clears and `data_oe` goes low. After reset the first strobe delivers byte 0 again.
- R2: Two clock edges after `ce_n` falls, with `rw` high and `done` low, `data_oe` is 1.
- R3: The stream holds 5*N+5 bytes, where N is `PAYLOAD_LEN`. Bytes 0 and 1 are the vector low and high bytes. Each payload item g takes five bytes: A9, (SEED + g*STEP) mod 256, 8D, low byte of (RAM_BASE+g), high byte of (RAM_BASE+g). The last three bytes are 4C, then the low and high bytes of RAM_BASE.
- R4: Without hold mode, `data_oe` falls two edges after `ce_n` rises. The pointer moves by exactly one on the third edge, and only on a deasserting edge.
- R5: Byte 1, the vector high byte, always has bit 7 set, whatever vector parameter is given.
- R6: When the last byte's strobe ends, `done` rises and stays high until reset. While `done` is high, `data_oe` stays 0.
- R7: Whenever `rw` is 0 (write), `data_oe` is 0 in the same instant, whether or not enable is asserted.
- R8: With `HOLD_EN`=1, after the strobe of byte k ends, `data_oe` stays 1 while `ce_n` is high and the next byte is shown, unless byte k is a store's high address byte or the last byte. In those two cases the bus is released.
- R9: While `ce_n` stays low, `data_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low enable strobe from the address decoder (asynchronous) |
| rw | input | 1 | Bus direction sense: 1 read, 0 write |
| data_out | output | 8 | Byte presented for the tri-state pad |
| data_oe | output | 1 | Pad output enable, 1 drives `data_out` |
| done | output | 1 | Sticky end-of-stream flag |

## Verification
A change on `ce_n` reaches `data_oe` after exactly two rising edges, which is the synchroniser depth. The pointer, and therefore `data_out`, moves on the third edge after `ce_n` rises. The `rw` gate acts with no clock delay. The bench drives every input on a falling edge. It samples the drive state three falling edges into a strobe and four falling edges after release, so every registered result has settled by then. `rw` is toggled between edges and checked one time unit later. The whole 25-byte stream is swept on a plain build and a hold build side by side, with expected bytes and hold decisions computed arithmetically from the stream layout.

// File: rtl/bootseq_pkg.sv
// bootseq_pkg: opcode values, stream layout constants and the function that
// computes one stream entry from its index. Assumes the 8-bit opcode set with
// immediate load (A9), absolute store (8D) and absolute jump (4C).
package bootseq_pkg;

    localparam logic [7:0] OP_LOAD_IMM  = 8'hA9;
    localparam logic [7:0] OP_STORE_ABS = 8'h8D;
    localparam logic [7:0] OP_JUMP_ABS  = 8'h4C;

    localparam int HDR_BYTES  = 2;
    localparam int COPY_BYTES = 5;
    localparam int JUMP_BYTES = 3;

    // One table slot: the byte itself and whether a CPU write cycle follows it.
    typedef struct packed {
        logic       wr_next;
        logic [7:0] value;
    } rom_entry_t;

    function automatic int stream_len(input int n_items);
        return HDR_BYTES + COPY_BYTES * n_items + JUMP_BYTES;
    endfunction

    // Computes stream entry idx for an n_items payload.
    function automatic rom_entry_t stream_entry(
        input int          idx,
        input int          n_items,
        input logic [15:0] vec,
        input logic [15:0] ram,
        input logic [7:0]  seed,
        input logic [7:0]  step
    );
        rom_entry_t  e;
        int          k;
        int          g;
        int          o;
        int          j;
        logic [15:0] dst;
        e = '0;
        if (idx == 0) begin
            e.value = vec[7:0];
        end else if (idx == 1) begin
            e.value = {1'b1, vec[14:8]};
        end else begin
            k = idx - HDR_BYTES;
            if (k < COPY_BYTES * n_items) begin
                g   = k / COPY_BYTES;
                o   = k % COPY_BYTES;
                dst = ram + 16'(g);
                case (o)
                    0:       e.value = OP_LOAD_IMM;
                    1:       e.value = seed + 8'(g) * step;
                    2:       e.value = OP_STORE_ABS;
                    3:       e.value = dst[7:0];
                    default: begin
                        e.value   = dst[15:8];
                        e.wr_next = 1'b1;
                    end
                endcase
            end else begin
                j = k - COPY_BYTES * n_items;
                case (j)
                    0:       e.value = OP_JUMP_ABS;
                    1:       e.value = ram[7:0];
                    default: e.value = ram[15:8];
                endcase
            end
        end
        return e;
    endfunction

endpackage

// File: rtl/bootseq_ce_sync.sv
// bootseq_ce_sync: brings the asynchronous active-low enable into the clock
// domain through STAGES flops and flags its deasserting (rising) edge.
// Assumes enable pulses last longer than STAGES+1 clock periods.
module bootseq_ce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES:0] sh_q;

    // Shift register: synchroniser stages plus one history flop, reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], ce_n_i};
        end
    end

    // Synchronised level and its rising edge.
    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/bootseq_rom.sv
// bootseq_rom: constant table of the boot stream, one entry per index,
// built by a generate loop from the package function, and a read mux.
// Assumes ptr_i stays below LEN; out-of-range reads return zero.
module bootseq_rom
    import bootseq_pkg::*;
#(
    parameter int          PAYLOAD_LEN  = 4,
    parameter logic [15:0] RESET_VECTOR = 16'hC000,
    parameter logic [15:0] RAM_BASE     = 16'h0300,
    parameter logic [7:0]  PAYLOAD_SEED = 8'h3C,
    parameter logic [7:0]  PAYLOAD_STEP = 8'h11,
    parameter int          LEN          = stream_len(PAYLOAD_LEN),
    parameter int          PTR_W        = $clog2(LEN + 1)
) (
    input  logic [PTR_W-1:0] ptr_i,
    output rom_entry_t       entry_o
);

    rom_entry_t table_w [LEN];

    genvar gi;
    generate
        for (gi = 0; gi < LEN; gi++) begin : g_slot
            assign table_w[gi] = stream_entry(gi, PAYLOAD_LEN, RESET_VECTOR,
                                              RAM_BASE, PAYLOAD_SEED, PAYLOAD_STEP);
        end
    endgenerate

    // Read mux: select the slot whose index equals the pointer.
    always_comb begin
        entry_o = '0;
        for (int i = 0; i < LEN; i++) begin
            if (ptr_i == PTR_W'(i)) begin
                entry_o = table_w[i];
            end
        end
    end

endmodule

// File: rtl/bootseq_seq.sv
// bootseq_seq: byte pointer, end-of-stream flag and optional hold decision.
// The pointer moves on each synchronised enable rise until the last byte;
// the rise on the last byte sets done instead. Assumes rise_i is one cycle wide.
module bootseq_seq #(
    parameter int LEN     = 25,
    parameter int PTR_W   = 5,
    parameter bit HOLD_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             rise_i,
    input  logic             wr_next_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             done_o,
    output logic             hold_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(LEN - 1);

    // Pointer and done flag: step on each deasserting edge of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o  <= '0;
            done_o <= 1'b0;
        end else if (rise_i && !done_o) begin
            if (ptr_o == LAST) begin
                done_o <= 1'b1;
            end else begin
                ptr_o <= ptr_o + PTR_W'(1);
            end
        end
    end

    generate
        if (HOLD_EN) begin : g_hold
            logic hold_q;
            // Hold decision: latched during the strobe for the byte being read.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= 1'b0;
                end else if (!level_i && !done_o) begin
                    hold_q <= !wr_next_i && (ptr_o != LAST);
                end
            end
            assign hold_o = hold_q;
        end else begin : g_nohold
            assign hold_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bootseq_streamer.sv
// bootseq_streamer: top of the sequential boot byte streamer. Ties together
// the enable synchroniser, the stream table and the sequencer, and forms the
// pad enable. Assumes rw is stable around the enable strobe; rw gates the
// drive without a clock so that a write cycle is never driven.
module bootseq_streamer
    import bootseq_pkg::*;
#(
    parameter int          PAYLOAD_LEN  = 4,
    parameter logic [15:0] RESET_VECTOR = 16'hC000,
    parameter logic [15:0] RAM_BASE     = 16'h0300,
    parameter logic [7:0]  PAYLOAD_SEED = 8'h3C,
    parameter logic [7:0]  PAYLOAD_STEP = 8'h11,
    parameter int          SYNC_STAGES  = 2,
    parameter bit          HOLD_EN      = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       rw,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       done
);

    localparam int LEN   = stream_len(PAYLOAD_LEN);
    localparam int PTR_W = $clog2(LEN + 1);

    logic             ce_level;
    logic             ce_rise;
    logic [PTR_W-1:0] ptr;
    logic             hold;
    rom_entry_t       entry;

    bootseq_ce_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n_i  (ce_n),
        .level_o (ce_level),
        .rise_o  (ce_rise)
    );

    bootseq_rom #(
        .PAYLOAD_LEN  (PAYLOAD_LEN),
        .RESET_VECTOR (RESET_VECTOR),
        .RAM_BASE     (RAM_BASE),
        .PAYLOAD_SEED (PAYLOAD_SEED),
        .PAYLOAD_STEP (PAYLOAD_STEP),
        .LEN          (LEN),
        .PTR_W        (PTR_W)
    ) u_rom (
        .ptr_i   (ptr),
        .entry_o (entry)
    );

    bootseq_seq #(
        .LEN     (LEN),
        .PTR_W   (PTR_W),
        .HOLD_EN (HOLD_EN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (ce_level),
        .rise_i    (ce_rise),
        .wr_next_i (entry.wr_next),
        .ptr_o     (ptr),
        .done_o    (done),
        .hold_o    (hold)
    );

    // Pad drive: strobe active or holding, read cycle, stream not finished.
    assign data_out = entry.value;
    assign data_oe  = !done && rw && (!ce_level || hold);

endmodule

// File: rtl/bootseq_streamer_chk.sv
// bootseq_streamer_chk: temporal checks on the streamer, bound into every
// instance of the top module.
module bootseq_streamer_chk #(
    parameter int LEN   = 25,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rw,
    input logic             ce_level,
    input logic [PTR_W-1:0] ptr,
    input logic [7:0]       data_out,
    input logic             data_oe,
    input logic             done
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(LEN - 1);

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> !data_oe);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !data_oe);

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_level) && !done && ptr != LAST) |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R4
    ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_level == $past(ce_level)) |=> (ptr == $past(ptr)));

    // R9
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_level && !$past(ce_level)) |-> $stable(data_out));

    // R5
    vector_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PTR_W'(1)) |-> data_out[7]);

endmodule

bind bootseq_streamer bootseq_streamer_chk #(
    .LEN   (LEN),
    .PTR_W (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rw       (rw),
    .ce_level (ce_level),
    .ptr      (ptr),
    .data_out (data_out),
    .data_oe  (data_oe),
    .done     (done)
);

// File: tb/bootseq_streamer_bench.sv
// Bench: sweeps the full stream on a plain build and a hold build in parallel.
module bootseq_streamer_bench;

    localparam int          N    = 4;
    localparam logic [15:0] VEC  = 16'h1234;
    localparam logic [15:0] RAM  = 16'h0300;
    localparam logic [7:0]  SEED = 8'h3C;
    localparam logic [7:0]  STEP = 8'h11;
    localparam int          LEN  = 5 * N + 5;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n  = 1'b1;
    logic       rw    = 1'b1;
    logic [7:0] d0, d1;
    logic       oe0, oe1, dn0, dn1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bootseq_streamer #(
        .PAYLOAD_LEN (N), .RESET_VECTOR (VEC), .RAM_BASE (RAM),
        .PAYLOAD_SEED (SEED), .PAYLOAD_STEP (STEP), .HOLD_EN (1'b0)
    ) u_bootseq_streamer (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .rw (rw),
        .data_out (d0), .data_oe (oe0), .done (dn0)
    );

    bootseq_streamer #(
        .PAYLOAD_LEN (N), .RESET_VECTOR (VEC), .RAM_BASE (RAM),
        .PAYLOAD_SEED (SEED), .PAYLOAD_STEP (STEP), .HOLD_EN (1'b1)
    ) u_bootseq_streamer_hold (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .rw (rw),
        .data_out (d1), .data_oe (oe1), .done (dn1)
    );

    // Expected byte k from the R3/R5 layout.
    function automatic logic [7:0] exp_byte(input int k);
        int m;
        logic [15:0] a;
        if (k == 0) return VEC[7:0];
        if (k == 1) return VEC[15:8] | 8'h80;
        m = k - 2;
        if (m < 5 * N) begin
            a = RAM + 16'(m / 5);
            case (m % 5)
                0: return 8'hA9;
                1: return 8'((int'(SEED) + (m / 5) * int'(STEP)) % 256);
                2: return 8'h8D;
                3: return a[7:0];
                default: return a[15:8];
            endcase
        end
        m = m - 5 * N;
        if (m == 0) return 8'h4C;
        if (m == 1) return RAM[7:0];
        return RAM[15:8];
    endfunction

    // Expected hold decision after byte k (R8).
    function automatic logic exp_hold(input int k);
        logic store_hi;
        store_hi = (k >= 2) && (k < 2 + 5 * N) && (((k - 2) % 5) == 4);
        return (k != LEN - 1) && !store_hi;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One enable strobe for byte k, optionally pulsing rw low mid-strobe.
    task automatic read_strobe(input int k, input bit glitch);
        @(negedge clk) ce_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 oe plain", {7'd0, oe0}, 8'd1);
        chk("R2 oe hold", {7'd0, oe1}, 8'd1);
        chk("R3 byte plain", d0, exp_byte(k));
        chk("R3 byte hold", d1, exp_byte(k));
        if (k == 1) chk("R5 vector bit7", {7'd0, d0[7]}, 8'd1);
        repeat (2) @(negedge clk);
        chk("R9 byte steady", d0, exp_byte(k));
        if (glitch) begin
            rw = 1'b0;
            #1;
            chk("R7 plain write gate", {7'd0, oe0}, 8'd0);
            chk("R7 hold write gate", {7'd0, oe1}, 8'd0);
            rw = 1'b1;
            #1;
            chk("R7 plain restore", {7'd0, oe0}, 8'd1);
        end
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 release", {7'd0, oe0}, 8'd0);
        chk("R8 hold drive", {7'd0, oe1}, {7'd0, exp_hold(k)});
        if (k < LEN - 1) begin
            chk("R4 advance plain", d0, exp_byte(k + 1));
            chk("R4 advance hold", d1, exp_byte(k + 1));
            chk("R6 done low", {7'd0, dn0}, 8'd0);
        end else begin
            chk("R6 done plain", {7'd0, dn0}, 8'd1);
            chk("R6 done hold", {7'd0, dn1}, 8'd1);
        end
        if (exp_hold(k)) begin
            rw = 1'b0;
            #1;
            chk("R7 hold write gate idle", {7'd0, oe1}, 8'd0);
            rw = 1'b1;
            #1;
        end
    endtask

    // Strobe after the end of stream: the bus must stay released.
    task automatic late_strobe();
        @(negedge clk) ce_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 silent plain", {7'd0, oe0}, 8'd0);
        chk("R6 silent hold", {7'd0, oe1}, 8'd0);
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 sticky", {7'd0, dn0 & dn1}, 8'd1);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe plain", {7'd0, oe0}, 8'd0);
        chk("R1 oe hold", {7'd0, oe1}, 8'd0);
        chk("R1 done", {7'd0, dn0 | dn1}, 8'd0);
        chk("R1 first byte", d0, exp_byte(0));
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int k = 0; k < LEN; k++) begin
            read_strobe(k, (k % 7) == 3);
        end
        late_strobe();
        late_strobe();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            read_strobe(k, 1'b0);
        end
        do_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule